// File: doc/BRIEF.md
# Addressable Bit Latch Bank with Demultiplex Mode

This block is a bank of eight level-sensitive storage bits that share one serial data input. A 3-bit select picks one bit, and an active-low enable together with an active-low clear chooses one of four modes. The block can write the selected bit, hold every bit, clear every bit, or act as a demultiplexer. In demultiplex mode the selected output follows the data input and every other output is driven low. The block has no clock. Each output is a transparent latch, so values move through as levels and are not sampled on edges.

To store a bit, the controller first places the select and the data while enable is high. It then pulls enable low and raises it again. The bit keeps the data value that was present when enable went high. Because the bits are latches, the select must not move while a write is open. The model reports such a change as a usage error. In demultiplex mode no bit is stored, so the select may change freely there. All pins are plain level controls, so there is no handshake and no back-pressure.

Top module: `addr_bit_latch`

## Requirements
- R1: With `wr_en_n`=1 and `clr_n`=0 (clear mode), all outputs are 0.
- R2: With `wr_en_n`=0 and `clr_n`=1 (write mode), the selected output is transparent and follows `din`.
- R3: In write mode, every output that is not selected keeps its previous value.
- R4: When `wr_en_n` rises in write mode, the selected output keeps the value `din` had at the rise. Later changes on `din` have no effect on it.
- R5: With `wr_en_n`=1 and `clr_n`=1 (hold mode), no output changes, whatever happens on `din` or `sel`.
- R6: With `wr_en_n`=0 and `clr_n`=0 (demultiplex mode), the selected output follows `din` and all other outputs are 0.
- R7: `sel` is an unsigned index with bit 2 as the MSB and bit 0 as the LSB. Index k selects `q[k]`, so 0 selects `q[0]` and 7 selects `q[7]`.
- R8: Changing `sel` while enable is high never alters the stored bits. A change of `sel` while in write mode is reported as a usage error by a simulation check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 1 | Serial data input |
| sel | input | 3 | Index of the selected output, bit 2 is the MSB |
| wr_en_n | input | 1 | Active-low enable that opens the selected bit |
| clr_n | input | 1 | Active-low clear (demultiplex mode when enable is also low) |
| q | output | 8 | Latch outputs, `q[k]` is bit k |

## Verification
Immediate assertions are checked on every settled input change. They cover the following:
- In clear mode all outputs are zero.
- In write mode the selected bit equals `din`.
- In demultiplex mode at most one output is high and the selected output equals `din`.
- In write mode `sel` keeps the value it had when enable fell.

Other behaviours cannot be checked from the current inputs alone, because they depend on history. These are retention of unselected bits, capture at the rising edge of enable, and the hold mode ignoring input changes. Only the bench scenarios can show them. The bench compares the outputs against an expected pattern after each input phase, and against a reference model that tracks the state across all eight indices.

// File: rtl/abl_pkg.sv
package abl_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_DEMUX = 2'd3
  } abl_mode_e;
endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
  import abl_pkg::*;
(
  input  logic      wr_en_n_i,
  input  logic      clr_n_i,
  output abl_mode_e mode_o
);
  always_comb begin
    case ({wr_en_n_i, clr_n_i})
      2'b01:   mode_o = MODE_WRITE;
      2'b10:   mode_o = MODE_CLEAR;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/abl_index_dec.sv
module abl_index_dec #(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [NBITS-1:0] hit_o
);
  for (genvar k = 0; k < NBITS; k++) begin : g_hit
    assign hit_o[k] = (sel_i == SEL_W'(k));
  end
endmodule

// File: rtl/abl_bit_cell.sv
module abl_bit_cell
  import abl_pkg::*;
(
  input  abl_mode_e mode_i,
  input  logic      hit_i,
  input  logic      din_i,
  output logic      q_o
);
  logic force_low;
  logic open_gate;

  // clear-all, or demultiplex on a bit that is not selected
  assign force_low = (mode_i == MODE_CLEAR) || ((mode_i == MODE_DEMUX) && !hit_i);
  assign open_gate = hit_i && ((mode_i == MODE_WRITE) || (mode_i == MODE_DEMUX));

  always_latch begin
    if (force_low)
      q_o = 1'b0;
    else if (open_gate)
      q_o = din_i;
  end
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import abl_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NBITS = 1 << SEL_W
) (
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             wr_en_n,
  input  logic             clr_n,
  output logic [NBITS-1:0] q
);
  abl_mode_e        mode;
  logic [NBITS-1:0] hit;

  abl_mode_dec u_mode (
    .wr_en_n_i (wr_en_n),
    .clr_n_i   (clr_n),
    .mode_o    (mode)
  );

  abl_index_dec #(.SEL_W(SEL_W)) u_index (
    .sel_i (sel),
    .hit_o (hit)
  );

  for (genvar k = 0; k < NBITS; k++) begin : g_cell
    abl_bit_cell u_cell (
      .mode_i (mode),
      .hit_i  (hit[k]),
      .din_i  (din),
      .q_o    (q[k])
    );
  end

  // Select value seen when the write window opened; follows sel otherwise.
  logic [SEL_W-1:0] sel_at_open;
  always_latch begin
    if (wr_en_n || !clr_n)
      sel_at_open = sel;
  end

  always_comb begin
    if (mode == MODE_CLEAR) begin
      // R1
      clear_all_chk: assert (q == '0) else $error("clear mode left a bit set");
    end
    if (mode == MODE_WRITE) begin
      // R2
      write_follow_chk: assert (q[sel] == din) else $error("selected bit not transparent");
      // R8
      sel_steady_chk: assert (sel == sel_at_open) else $error("sel moved during write");
    end
    if (mode == MODE_DEMUX) begin
      // R6
      demux_onehot_chk: assert ($countones(q) <= 1) else $error("demux drove several bits");
      // R6
      demux_follow_chk: assert (q[sel] == din) else $error("demux selected bit wrong");
    end
  end
endmodule

// File: tb/tb_addr_bit_latch.sv
`timescale 1ns/1ps
module tb_addr_bit_latch;
  logic       clk = 1'b0;
  logic       din = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       wr_en_n = 1'b1;
  logic       clr_n = 1'b0;
  logic [7:0] q;
  logic [7:0] ref_q = 8'h00;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  addr_bit_latch dut (.din(din), .sel(sel), .wr_en_n(wr_en_n), .clr_n(clr_n), .q(q));

  typedef struct packed {
    logic       en_n;
    logic       cl_n;
    logic [2:0] a;
    logic       d;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd0, 1'b0, 8'h00},  // R1 clear
    '{1'b1, 1'b1, 3'd0, 1'b0, 8'h00},  // R5 hold
    '{1'b0, 1'b1, 3'd3, 1'b1, 8'h08},  // R2 R7 write q3
    '{1'b0, 1'b1, 3'd3, 1'b0, 8'h00},  // R2 follows
    '{1'b0, 1'b1, 3'd3, 1'b1, 8'h08},
    '{1'b1, 1'b1, 3'd3, 1'b1, 8'h08},  // R4 capture
    '{1'b1, 1'b1, 3'd5, 1'b0, 8'h08},  // R5 ignore
    '{1'b1, 1'b1, 3'd6, 1'b1, 8'h08},
    '{1'b0, 1'b1, 3'd6, 1'b1, 8'h48},  // R3 q3 kept
    '{1'b1, 1'b1, 3'd6, 1'b0, 8'h48},  // R4 din drop after rise
    '{1'b0, 1'b1, 3'd0, 1'b1, 8'h49},
    '{1'b1, 1'b1, 3'd0, 1'b1, 8'h49},
    '{1'b0, 1'b0, 3'd2, 1'b1, 8'h04},  // R6 demux
    '{1'b0, 1'b0, 3'd2, 1'b0, 8'h00},
    '{1'b0, 1'b0, 3'd7, 1'b1, 8'h80},  // R6 sel moves in demux
    '{1'b0, 1'b1, 3'd7, 1'b1, 8'h80},  // R2 R3 demux to write
    '{1'b1, 1'b1, 3'd7, 1'b1, 8'h80},
    '{1'b1, 1'b0, 3'd7, 1'b1, 8'h00},  // R1
    '{1'b1, 1'b1, 3'd4, 1'b1, 8'h00}   // R5
  };

  function automatic logic [7:0] ref_step(logic [7:0] cur, logic en_n, logic cl_n,
                                          logic [2:0] a, logic d);
    logic [7:0] nx = cur;
    if (en_n && !cl_n) nx = 8'h00;
    else if (!en_n && !cl_n) begin nx = 8'h00; nx[a] = d; end
    else if (!en_n) nx[a] = d;
    return nx;
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%h expected %h", tag, q, exp);
    end
  endtask

  task automatic apply(logic en_n, logic cl_n, logic [2:0] a, logic d);
    @(posedge clk);
    if (en_n) wr_en_n = 1'b1;
    #0.5 ref_q = ref_step(ref_q, wr_en_n, clr_n, sel, din);
    #0.5 sel = a; din = d; clr_n = cl_n;
    #0.5 ref_q = ref_step(ref_q, wr_en_n, clr_n, sel, din);
    #0.5 wr_en_n = en_n;
    #0.2 ref_q = ref_step(ref_q, wr_en_n, clr_n, sel, din);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] snap;
    apply(1'b1, 1'b0, 3'd0, 1'b0);
    check("R1 initial clear", 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].en_n, VECS[i].cl_n, VECS[i].a, VECS[i].d);
      check($sformatf("R1-table vector %0d (R2/R3/R4/R5/R6)", i), VECS[i].exp);
    end

    // R7 R3: set each index in turn, accumulating bits
    apply(1'b1, 1'b0, 3'd0, 1'b0);
    for (int a = 0; a < 8; a++) begin
      apply(1'b1, 1'b1, 3'(a), 1'b1);
      apply(1'b0, 1'b1, 3'(a), 1'b1);
      apply(1'b1, 1'b1, 3'(a), 1'b1);
      check($sformatf("R7 write index %0d", a), ref_q);
    end
    check("R7 all set", 8'hFF);

    // R8: sweep sel and din with enable high, stored pattern stays
    apply(1'b1, 1'b1, 3'd1, 1'b0);
    apply(1'b0, 1'b1, 3'd1, 1'b0);
    apply(1'b1, 1'b1, 3'd1, 1'b1);
    snap = q;
    check("R4 clear bit1 kept", 8'hFD);
    for (int a = 0; a < 8; a++) begin
      apply(1'b1, 1'b1, 3'(a), a[0]);
      check($sformatf("R8 sel %0d with enable high", a), snap);
    end

    // R6: demultiplex every index
    for (int a = 0; a < 8; a++) begin
      apply(1'b0, 1'b0, 3'(a), 1'b1);
      check($sformatf("R6 demux index %0d", a), 8'(1 << a));
      if (ref_q !== 8'(1 << a)) begin
        checks++; fails++;
        $display("FAIL R6 model: ref=%h expected %h", ref_q, 8'(1 << a));
      end
    end
    apply(1'b0, 1'b0, 3'd5, 1'b0);
    check("R6 demux din low", 8'h00);

    // R5 R1 after demux
    apply(1'b1, 1'b1, 3'd5, 1'b0);
    check("R5 hold after demux", 8'h00);
    finish_run();
  end
endmodule